// File: doc/BRIEF.md
# Permutation-Safe Tour Recombiner

This block builds one child tour from two parent tours for a search engine that evolves city orderings. A tour is a list of N city indices, each city present exactly once. A plain bitwise crossover of two such lists would repeat some cities and drop others. This unit keeps a bit vector of cities not yet placed, so the child is always a valid ordering. In crossover mode it copies a head segment from the first parent. It then takes the second parent's city at each later position only if that city is still free, and leaves a gap otherwise. A final pass fills every gap with a free city chosen at random. In mutation mode it swaps the cities at two random positions of the first parent.

Randomness enters through the `rnd_in` port, which is sampled once per clock. The surrounding engine supplies it, usually from a shift-register generator. The work advances one tour position per clock. A one-cycle `done` pulse marks the child as ready on `tour_out`. The parents must be held stable from `start` until `done`.

Top module: `tour_xover`

## Requirements
- R1: While idle, `start` high on a rising edge begins an operation. The mode is latched from `op_mut` (0 = crossover, 1 = swap mutation). A `start` seen while an operation is running is ignored: it changes neither the result nor the timing.
- R2: In crossover, the cut is `rnd_in mod N`, sampled on the start edge. Positions 0 up to and including the cut take the city at the same position of `parent_a`. Position p occupies bits [p*IW +: IW] of each tour bus.
- R3: In crossover, each position after the cut takes `parent_b`'s city at that position if that city is still free. Otherwise the position becomes a gap. Positions are visited in ascending order, one per clock, on edges 1 to N after the start edge.
- R4: The fill pass visits positions 0 to N-1 on edges N+1 to 2N after the start edge. At a gap it samples k = `rnd_in mod F`, where F is the number of free cities. It places the free city of k-th smallest index (counting from 0) and marks that city used.
- R5: In mutation, i = `rnd_in mod N` is sampled on edge 1 after start and j = `rnd_in mod N` on edge 2. The output is `parent_a` with positions i and j exchanged. When i equals j, the output equals `parent_a`.
- R6: Whenever `done` is high, `tour_out` holds every city 0..N-1 exactly once.
- R7: `done` is high in the cycle after edge 2N past the start edge for crossover, and after edge 2 for mutation.
- R8: `done` lasts one cycle. `tour_out` then keeps its value until the next accepted `start`.
- R9: After reset, `done` is low and `tour_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op_mut | input | 1 | 0 = crossover, 1 = swap mutation |
| parent_a | input | N_CITY*IW | First parent tour |
| parent_b | input | N_CITY*IW | Second parent tour |
| rnd_in | input | RND_W | Random word, sampled each clock |
| tour_out | output | N_CITY*IW | Child tour |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the extreme cuts: a cut at 0 leaves almost everything to the second parent, and a cut at N-1 must reproduce the first parent. An off-by-one in the cut compare shows up at once in those two cases. It uses parent pairs with many conflicts, such as an identity tour against its reverse. Those pairs leave gaps, so a wrong choice of free city or a wrong pool count produces a repeated city or a different order. It forces equal swap positions, where a bad swap would write a stale value. It also pulses `start` in the middle of a run, which a design that restarts would answer with a late or altered `done`.

// File: rtl/tour_xover.sv
module tour_xover #(
  parameter int N_CITY = 8,
  parameter int RND_W  = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 op_mut,
  input  logic [N_CITY*$clog2(N_CITY)-1:0]     parent_a,
  input  logic [N_CITY*$clog2(N_CITY)-1:0]     parent_b,
  input  logic [RND_W-1:0]                     rnd_in,
  output logic [N_CITY*$clog2(N_CITY)-1:0]     tour_out,
  output logic                                 done
);
  localparam int IW = $clog2(N_CITY);
  localparam int CW = $clog2(N_CITY + 1);

  typedef enum logic [2:0] {S_IDLE, S_COPY, S_FILL, S_MI, S_MJ, S_DONE} st_t;
  st_t st;

  logic [IW-1:0]     pa [N_CITY];
  logic [IW-1:0]     pb [N_CITY];
  logic [IW-1:0]     tour [N_CITY];
  logic [N_CITY-1:0] pool, gap;
  logic [IW-1:0]     pos, cut, mi, pick;
  logic              op_q;
  logic [CW-1:0]     free_cnt, cnt_nz, seen;
  logic [RND_W-1:0]  rmod_n, rmod_k;
  logic              found;
  logic              last_pos;

  for (genvar g = 0; g < N_CITY; g++) begin : g_slice
    assign pa[g] = parent_a[g*IW +: IW];
    assign pb[g] = parent_b[g*IW +: IW];
    assign tour_out[g*IW +: IW] = tour[g];
  end

  assign rmod_n   = rnd_in % RND_W'(N_CITY);
  assign cnt_nz   = (free_cnt == '0) ? CW'(1) : free_cnt;
  assign rmod_k   = rnd_in % RND_W'(cnt_nz);
  assign last_pos = (pos == IW'(N_CITY - 1));
  assign done     = (st == S_DONE);

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < N_CITY; i++) free_cnt = free_cnt + CW'(pool[i]);
  end

  always_comb begin
    pick  = '0;
    seen  = '0;
    found = 1'b0;
    for (int i = 0; i < N_CITY; i++) begin
      if (pool[i] && !found) begin
        if (seen == rmod_k[CW-1:0]) begin
          pick  = IW'(i);
          found = 1'b1;
        end
        seen = seen + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pool <= '0;
      gap  <= '0;
      pos  <= '0;
      cut  <= '0;
      mi   <= '0;
      op_q <= 1'b0;
      for (int i = 0; i < N_CITY; i++) tour[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q <= op_mut;
          for (int i = 0; i < N_CITY; i++) tour[i] <= pa[i];
          pool <= '1;
          gap  <= '0;
          pos  <= '0;
          cut  <= rmod_n[IW-1:0];
          st   <= op_mut ? S_MI : S_COPY;
        end
        S_COPY: begin
          if (pos <= cut) begin
            tour[pos]     <= pa[pos];
            pool[pa[pos]] <= 1'b0;
          end else if (pool[pb[pos]]) begin
            tour[pos]     <= pb[pos];
            pool[pb[pos]] <= 1'b0;
          end else begin
            gap[pos] <= 1'b1;
          end
          pos <= last_pos ? '0 : pos + 1'b1;
          if (last_pos) st <= S_FILL;
        end
        S_FILL: begin
          if (gap[pos]) begin
            tour[pos]  <= pick;
            pool[pick] <= 1'b0;
            gap[pos]   <= 1'b0;
          end
          pos <= last_pos ? '0 : pos + 1'b1;
          if (last_pos) st <= S_DONE;
        end
        S_MI: begin
          mi <= rmod_n[IW-1:0];
          st <= S_MJ;
        end
        S_MJ: begin
          tour[mi]              <= tour[rmod_n[IW-1:0]];
          tour[rmod_n[IW-1:0]]  <= tour[mi];
          st                    <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tour_xover_chk.sv
module tour_xover_chk #(
  parameter int N_CITY = 8,
  parameter int IW     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done,
  input logic                 op_q,
  input logic [N_CITY-1:0]    pool,
  input logic [N_CITY*IW-1:0] tour_out,
  input logic [N_CITY*IW-1:0] parent_a
);
  logic [N_CITY-1:0] hit;
  int unsigned       ndiff;

  always_comb begin
    hit   = '0;
    ndiff = 0;
    for (int i = 0; i < N_CITY; i++) begin
      hit[tour_out[i*IW +: IW]] = 1'b1;
      if (tour_out[i*IW +: IW] != parent_a[i*IW +: IW]) ndiff = ndiff + 1;
    end
  end

  assert_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hit == {N_CITY{1'b1}}));

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_pool_spent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q) |-> (pool == '0));

  assert_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q) |-> (tour_out[IW-1:0] == parent_a[IW-1:0]));

  assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |-> (ndiff == 0 || ndiff == 2));
endmodule

bind tour_xover tour_xover_chk #(.N_CITY(N_CITY), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .op_q(op_q), .pool(pool),
  .tour_out(tour_out), .parent_a(parent_a)
);

// File: tb/tour_xover_bench.sv
module tour_xover_bench;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int RW = 16;
  localparam int NR = 2*N + 3;

  logic clk = 0, rst_n = 0, start = 0, op_mut = 0;
  logic [N*IW-1:0] parent_a = '0, parent_b = '0, tour_out;
  logic [RW-1:0] rnd_in = '0;
  logic done;

  tour_xover #(.N_CITY(N), .RND_W(RW)) u_tour_xover (
    .clk(clk), .rst_n(rst_n), .start(start), .op_mut(op_mut),
    .parent_a(parent_a), .parent_b(parent_b), .rnd_in(rnd_in),
    .tour_out(tour_out), .done(done)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  int unsigned lcg = 32'h1234_5678;
  int pa[N], pb[N], expt[N], rv[NR];
  int glitch_c = -1;

  function automatic int unsigned nxt();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return (lcg >> 16) & 32'hffff;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic shuffle(ref int t[N]);
    for (int i = 0; i < N; i++) t[i] = i;
    for (int i = N-1; i > 0; i--) begin
      int j, tmp;
      j = int'(nxt() % (i+1));
      tmp = t[i]; t[i] = t[j]; t[j] = tmp;
    end
  endtask

  task automatic fill_rv();
    for (int i = 0; i < NR; i++) rv[i] = int'(nxt());
  endtask

  function automatic int got_at(int p);
    return int'(tour_out[p*IW +: IW]);
  endfunction

  task automatic model(input bit m);
    if (m) begin
      int i, j, tmp;
      for (int p = 0; p < N; p++) expt[p] = pa[p];
      i = rv[1] % N; j = rv[2] % N;
      tmp = expt[i]; expt[i] = expt[j]; expt[j] = tmp;
    end else begin
      int freeq[$];
      bit gp[N];
      int cut;
      for (int c = 0; c < N; c++) freeq.push_back(c);
      cut = rv[0] % N;
      for (int p = 0; p < N; p++) begin
        int hitq[$];
        gp[p] = 0;
        if (p <= cut) begin
          expt[p] = pa[p];
          hitq = freeq.find_first_index(x) with (x == pa[p]);
          if (hitq.size() > 0) freeq.delete(hitq[0]);
        end else begin
          hitq = freeq.find_first_index(x) with (x == pb[p]);
          if (hitq.size() > 0) begin
            expt[p] = pb[p];
            freeq.delete(hitq[0]);
          end else gp[p] = 1;
        end
      end
      for (int p = 0; p < N; p++) if (gp[p]) begin
        int k;
        k = rv[N+1+p] % freeq.size();
        expt[p] = freeq[k];
        freeq.delete(k);
      end
    end
  endtask

  task automatic run(input bit m, input string tag);
    int last;
    last = m ? 3 : 2*N + 1;
    for (int i = 0; i < N; i++) begin
      parent_a[i*IW +: IW] = IW'(pa[i]);
      parent_b[i*IW +: IW] = IW'(pb[i]);
    end
    model(m);
    for (int c = 0; c <= last + 1; c++) begin
      @(negedge clk);
      if (c > 0) chk({tag, " R7 done timing"}, int'(done), int'(c == last));
      if (c == last || c == last + 1) begin
        bit [N-1:0] seenb;
        seenb = '0;
        for (int p = 0; p < N; p++) begin
          chk({tag, (c == last) ? " R2/R3/R4/R5 tour" : " R8 hold"}, got_at(p), expt[p]);
          seenb[got_at(p)] = 1'b1;
        end
        chk({tag, " R6 permutation"}, int'(seenb), (1 << N) - 1);
      end
      rnd_in = (c < NR) ? RW'(rv[c]) : '0;
      start  = (c == 0) || (c == glitch_c);
      op_mut = m;
    end
    start = 0;
    glitch_c = -1;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset tour", int'(tour_out), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin pa[i] = i; pb[i] = i; end
    fill_rv(); rv[0] = 0;
    run(0, "xo same cut0 R2");
    fill_rv(); rv[0] = N - 1;
    for (int i = 0; i < N; i++) pb[i] = N - 1 - i;
    run(0, "xo cutmax R2");
    for (int s = 0; s < N; s++) begin
      fill_rv(); rv[0] = s;
      run(0, "xo rev R3 R4");
    end
    for (int t = 0; t < 12; t++) begin
      shuffle(pa); shuffle(pb); fill_rv();
      run(0, "xo rand R3 R4");
    end
    shuffle(pa); shuffle(pb); fill_rv(); glitch_c = 5;
    run(0, "xo busy start R1");
    shuffle(pa); fill_rv(); rv[1] = 3; rv[2] = 11;
    run(1, "mut same pos R5");
    for (int t = 0; t < 10; t++) begin
      shuffle(pa); fill_rv();
      run(1, "mut rand R5");
    end
    shuffle(pa); fill_rv(); glitch_c = 2;
    run(1, "mut busy start R1");
    shuffle(pa); shuffle(pb); fill_rv(); rv[0] = 2;
    run(0, "xo after mut R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule